// File: doc/BRIEF.md
# Command Queue Processing Engine

This block drains a circular command queue that software keeps in memory. Each queue slot is 32 bytes, four 64-bit doublewords. While the engine is enabled and not stalled, it compares its own read offset with the write offset that software publishes. As long as the two differ, it fetches the first doubleword of the slot at the read offset over a simple request/acknowledge memory port. It then decodes the low byte as the command code.

A recognised code is handed to an external command handler through a request/done interface, together with the fetched doubleword and the slot address. The handler answers either continue or stall. On continue the read offset moves to the next slot, wrapping at the programmed depth. On a stall answer, or on a bus error during the fetch, the engine raises a sticky stalled flag and freezes the read offset on the failing slot. Codes the engine does not recognise are skipped as no-ops.

Software sets the queue base address and depth with a configuration strobe while the engine is disabled. That strobe also rewinds the read offset to zero and clears the stalled flag.

Top module: `cmdq_engine`

## Requirements
- R1: After reset, rd_offset is 0, stalled is 0, and neither mem_req nor hnd_req is asserted.
- R2: A fetch starts only while enable is 1, stalled is 0 and rd_offset differs from wr_offset. With enable at 0, pending slots are left untouched. Raising enable drains them.
- R3: The fetch address is the programmed base plus rd_offset times 32. It is held stable while mem_req waits for mem_ack.
- R4: The command code is bits [7:0] of the fetched doubleword. By default the codes 0x01 to 0x0F are recognised. A recognised command raises hnd_req with hnd_code, the full doubleword on hnd_cmd and the slot address on hnd_addr, and holds hnd_req until hnd_done.
- R5: A continue answer (hnd_done with hnd_stall low) advances rd_offset by one. After slot depth-1 it wraps to 0, where a programmed depth of 0 means 2^IDX_W slots.
- R6: A stall answer (hnd_done with hnd_stall high) sets stalled, leaves rd_offset on the failing slot and ends processing.
- R7: A fetch that completes with mem_err high sets stalled, leaves rd_offset unchanged, and does not call the handler.
- R8: Unrecognised codes (0x00 and 0x10 to 0xFF by default) advance rd_offset without raising hnd_req.
- R9: A cfg_we pulse while enable is 0 and no command is in flight loads base and depth, sets rd_offset to 0 and clears stalled. A pulse while enable is 1 is ignored.
- R10: Once set, stalled stays set and no fetch is made across changes of wr_offset and toggles of enable, until a reconfiguration or reset.
- R11: Moving wr_offset while enabled and not stalled resumes processing from the current rd_offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Engine enable |
| cfg_we | input | 1 | Configuration strobe for base and depth |
| cfg_base | input | ADDR_W | Queue base byte address |
| cfg_depth | input | IDX_W+1 | Number of queue slots (0 means 2^IDX_W) |
| wr_offset | input | IDX_W | Software write offset, in slots |
| rd_offset | output | IDX_W | Engine read offset, in slots |
| stalled | output | 1 | Sticky stall flag |
| mem_req | output | 1 | Fetch request |
| mem_addr | output | ADDR_W | Fetch byte address |
| mem_ack | input | 1 | Fetch completion |
| mem_err | input | 1 | Bus error, valid with mem_ack |
| mem_rdata | input | 64 | Fetched doubleword, valid with mem_ack |
| hnd_req | output | 1 | Handler request, held until hnd_done |
| hnd_code | output | 8 | Command code |
| hnd_cmd | output | 64 | First doubleword of the command |
| hnd_addr | output | ADDR_W | Byte address of the command slot |
| hnd_done | input | 1 | Handler completion |
| hnd_stall | input | 1 | Handler answer: 1 stall, 0 continue; valid with hnd_done |

## Verification
The bench builds the engine with IDX_W=3 and 16-bit addresses, which keeps every queue depth from 1 to 8 within a short run. It sweeps all eight depths. For each depth it drains the queue and then pushes across the wrap point, so that both the single-slot queue and the full power-of-two queue (depth 0 encoding excluded) are covered. Slot contents come from a formula of the slot address that includes the code boundaries 0x00, 0x0F and 0x10. This lets the expected handler calls, addresses and final offsets be derived by arithmetic. Stall answers and bus errors are injected at a chosen slot, followed by writes to wr_offset, toggles of enable and a reconfiguration.

// File: rtl/cmdq_engine.sv
module cmdq_engine #(
  parameter int ADDR_W = 32,
  parameter int IDX_W = 4,
  parameter int SLOT_LG = 5,
  parameter logic [255:0] KNOWN_CODES = 256'hFFFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [IDX_W:0]    cfg_depth,
  input  logic [IDX_W-1:0]  wr_offset,
  output logic [IDX_W-1:0]  rd_offset,
  output logic              stalled,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic              mem_err,
  input  logic [63:0]       mem_rdata,
  output logic              hnd_req,
  output logic [7:0]        hnd_code,
  output logic [63:0]       hnd_cmd,
  output logic [ADDR_W-1:0] hnd_addr,
  input  logic              hnd_done,
  input  logic              hnd_stall
);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_RUN} state_t;

  state_t              state;
  logic [IDX_W-1:0]    rd_q;
  logic                stall_q;
  logic [ADDR_W-1:0]   base_q;
  logic [IDX_W:0]      depth_q;
  logic [63:0]         cmd_q;

  logic [IDX_W-1:0]    rd_next;
  logic                go;
  logic                cfg_ok;
  logic [ADDR_W-1:0]   slot_addr;

  assign go        = enable && !stall_q && (rd_q != wr_offset);
  assign cfg_ok    = cfg_we && !enable && (state == S_IDLE);
  assign rd_next   = (({1'b0, rd_q} + (IDX_W+1)'(1)) == depth_q) ? '0 : rd_q + IDX_W'(1);
  assign slot_addr = base_q + (ADDR_W'(rd_q) << SLOT_LG);

  assign rd_offset = rd_q;
  assign stalled   = stall_q;
  assign mem_req   = (state == S_FETCH);
  assign mem_addr  = slot_addr;
  assign hnd_req   = (state == S_RUN);
  assign hnd_code  = cmd_q[7:0];
  assign hnd_cmd   = cmd_q;
  assign hnd_addr  = slot_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      rd_q    <= '0;
      stall_q <= 1'b0;
      base_q  <= '0;
      depth_q <= '0;
      cmd_q   <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (cfg_ok) begin
            base_q  <= cfg_base;
            depth_q <= cfg_depth;
            rd_q    <= '0;
            stall_q <= 1'b0;
          end else if (go) begin
            state <= S_FETCH;
          end
        end
        S_FETCH: begin
          if (mem_ack) begin
            if (mem_err) begin
              stall_q <= 1'b1;
              state   <= S_IDLE;
            end else begin
              cmd_q <= mem_rdata;
              if (KNOWN_CODES[mem_rdata[7:0]]) begin
                state <= S_RUN;
              end else begin
                rd_q  <= rd_next;
                state <= S_IDLE;
              end
            end
          end
        end
        S_RUN: begin
          if (hnd_done) begin
            if (hnd_stall) stall_q <= 1'b1;
            else           rd_q    <= rd_next;
            state <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_empty_no_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_req && !hnd_req && rd_offset == wr_offset) |=> !mem_req);

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  p_stall_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hnd_req && hnd_done && hnd_stall) |=> (stalled && $stable(rd_offset)));

  p_stall_buserr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_err) |=> (stalled && $stable(rd_offset) && !hnd_req));

  p_stalled_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |=> !mem_req);

endmodule

// File: tb/cmdq_engine_tb.sv
module cmdq_engine_tb;
  localparam int AW = 16;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic          cfg_we = 1'b0;
  logic [AW-1:0] cfg_base = '0;
  logic [IW:0]   cfg_depth = '0;
  logic [IW-1:0] wr_offset = '0;
  logic [IW-1:0] rd_offset;
  logic          stalled;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_ack = 1'b0;
  logic          mem_err = 1'b0;
  logic [63:0]   mem_rdata = '0;
  logic          hnd_req;
  logic [7:0]    hnd_code;
  logic [63:0]   hnd_cmd;
  logic [AW-1:0] hnd_addr;
  logic          hnd_done = 1'b0;
  logic          hnd_stall = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  int log_n = 0;
  int fetch_n = 0;
  logic [7:0]    log_code [0:63];
  logic [AW-1:0] log_addr [0:63];
  logic [AW-1:0] log_hi   [0:63];
  logic [7:0]    stall_code = 8'hFF;
  logic [AW-1:0] err_addr = 16'hFFFF;

  always #5 clk = ~clk;

  cmdq_engine #(.ADDR_W(AW), .IDX_W(IW)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we),
    .cfg_base(cfg_base), .cfg_depth(cfg_depth), .wr_offset(wr_offset),
    .rd_offset(rd_offset), .stalled(stalled),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_err(mem_err), .mem_rdata(mem_rdata),
    .hnd_req(hnd_req), .hnd_code(hnd_code), .hnd_cmd(hnd_cmd),
    .hnd_addr(hnd_addr), .hnd_done(hnd_done), .hnd_stall(hnd_stall)
  );

  function automatic logic [7:0] code_of(int idx);
    case (idx)
      2: return 8'h10;
      5: return 8'h00;
      7: return 8'h0F;
      default: return 8'(8'h01 + idx);
    endcase
  endfunction

  function automatic bit known(logic [7:0] c);
    return (c >= 8'h01) && (c <= 8'h0F);
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory and handler models
  initial forever begin
    @(negedge clk);
    if (mem_ack) begin
      mem_ack = 1'b0;
      mem_err = 1'b0;
    end else if (mem_req) begin
      mem_ack   = 1'b1;
      mem_err   = (mem_addr == err_addr);
      mem_rdata = {mem_addr, 40'h0, code_of(int'((mem_addr >> 5) & 7))};
      fetch_n++;
    end
    if (hnd_done) begin
      hnd_done  = 1'b0;
      hnd_stall = 1'b0;
    end else if (hnd_req) begin
      hnd_done  = 1'b1;
      hnd_stall = (hnd_code == stall_code);
      if (log_n < 64) begin
        log_code[log_n] = hnd_code;
        log_addr[log_n] = hnd_addr;
        log_hi[log_n]   = hnd_cmd[63:48];
      end
      log_n++;
    end
  end

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
      end
    end
  end

  task automatic configure(input logic [AW-1:0] b, input int d);
    @(negedge clk);
    cfg_base  = b;
    cfg_depth = (IW+1)'(d);
    cfg_we    = 1'b1;
    @(negedge clk);
    cfg_we    = 1'b0;
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (100) @(negedge clk);
  endtask

  // drive wr_offset, then compare handler log against the arithmetic expectation
  task automatic round(input int d, input int start, input int stop, input logic [AW-1:0] b);
    int idx = start;
    int k = 0;
    int nf = 0;
    log_n = 0;
    fetch_n = 0;
    wr_offset = IW'(stop);
    settle();
    while (idx != stop) begin
      logic [7:0] c = code_of(idx);
      nf++;
      if (known(c)) begin
        check("R4 code", log_code[k], c);
        check("R3 address", log_addr[k], b + AW'(idx * 32));
        check("R4 doubleword", log_hi[k], b + AW'(idx * 32));
        k++;
      end
      idx = (idx + 1) % d;
    end
    check("R8 handler calls", log_n, k);
    check("R2 fetch count", fetch_n, nf);
    check("R5 rd_offset", rd_offset, stop);
    check("R5 not stalled", stalled, 0);
  endtask

  initial begin
    logic [AW-1:0] b;
    repeat (3) @(negedge clk);
    check("R1 rd_offset", rd_offset, 0);
    check("R1 stalled", stalled, 0);
    check("R1 mem_req", mem_req, 0);
    check("R1 hnd_req", hnd_req, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep every depth, drain then cross the wrap point
    for (int d = 1; d <= 8; d++) begin
      b = AW'(16'h1000 + d * 16'h0100);
      enable = 1'b0;
      wr_offset = '0;
      configure(b, d);
      check("R9 rd after config", rd_offset, 0);
      enable = 1'b1;
      round(d, 0, d - 1, b);
      round(d, d - 1, (d >= 3) ? 1 : 0, b);
    end

    // disabled: pending slots left alone, enable drains them (R2)
    b = 16'h2000;
    enable = 1'b0;
    wr_offset = '0;
    configure(b, 8);
    log_n = 0;
    fetch_n = 0;
    wr_offset = 3'd4;
    settle();
    check("R2 no fetch disabled", fetch_n, 0);
    check("R2 rd held disabled", rd_offset, 0);
    enable = 1'b1;
    settle();
    check("R2 drained on enable", rd_offset, 4);

    // cfg while enabled ignored (R9), later addresses still use old base
    configure(16'h3000, 2);
    check("R9 ignored rd", rd_offset, 4);
    round(8, 4, 7, b);

    // stall answer (R6, R10, R9)
    enable = 1'b0;
    wr_offset = '0;
    configure(b, 8);
    enable = 1'b1;
    stall_code = code_of(3);
    log_n = 0;
    wr_offset = 3'd6;
    settle();
    check("R6 rd frozen", rd_offset, 3);
    check("R6 stalled", stalled, 1);
    check("R6 handler calls", log_n, 3);
    log_n = 0;
    fetch_n = 0;
    wr_offset = 3'd7;
    settle();
    enable = 1'b0;
    repeat (5) @(negedge clk);
    enable = 1'b1;
    settle();
    check("R10 still stalled", stalled, 1);
    check("R10 rd held", rd_offset, 3);
    check("R10 no fetch", fetch_n, 0);
    stall_code = 8'hFF;
    enable = 1'b0;
    configure(b, 8);
    check("R9 stall cleared", stalled, 0);
    check("R9 rd rewound", rd_offset, 0);
    enable = 1'b1;
    settle();
    check("R11 resumed", rd_offset, 7);

    // bus error on fetch (R7)
    enable = 1'b0;
    wr_offset = '0;
    configure(b, 8);
    enable = 1'b1;
    err_addr = b + AW'(4 * 32);
    log_n = 0;
    wr_offset = 3'd6;
    settle();
    check("R7 rd frozen", rd_offset, 4);
    check("R7 stalled", stalled, 1);
    check("R7 handler calls", log_n, 3);
    err_addr = 16'hFFFF;
    enable = 1'b0;
    configure(b, 8);
    check("R9 clear after error", stalled, 0);

    // write offset moves while running resumes (R11)
    enable = 1'b1;
    wr_offset = 3'd2;
    settle();
    check("R11 first part", rd_offset, 2);
    round(8, 2, 5, b);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule